// File: doc/BRIEF.md
# Drop Bus Parity Monitor

This block watches a byte-wide drop bus and checks odd parity on every beat that carries a parity bit. Three selections decide which signals the parity bit covers. With pointer tracking off, it covers the data byte, the payload-envelope flag and the combined frame/J1 marker. With pointer tracking on, it covers the data byte and the frame-start marker. When the data-only control is set, it covers the data byte alone, whatever the tracking mode. The selection is made from the control inputs on each cycle, so it can change while the bus is running.

The block only observes the bus. It has no data output and never alters the traffic. When a checked beat fails, it raises a one-cycle error pulse on the cycle after that beat. It also sets a sticky alarm bit, which stays high until a processor write-one-to-clear strobe removes it. If an error and a clear arrive in the same cycle, the error wins and the alarm stays set.

Top module: `drop_par_chk`

## Requirements
- R1: After reset, `err_pulse` and `alarm` are both 0.
- R2: With `trk_en`=0 and `dat_only`=0, a checked beat is in error when the eight `bus_data` bits, `bus_spe`, `bus_fj1` and `bus_par` together hold an even number of ones. `bus_c1` is ignored in this mode.
- R3: With `trk_en`=1 and `dat_only`=0, a checked beat is in error when the eight `bus_data` bits, `bus_c1` and `bus_par` together hold an even number of ones. `bus_spe` and `bus_fj1` are ignored in this mode.
- R4: With `dat_only`=1, in either tracking mode, a checked beat is in error when the eight `bus_data` bits and `bus_par` together hold an even number of ones. `bus_spe`, `bus_fj1` and `bus_c1` are ignored.
- R5: A beat is checked only in a cycle where `bus_vld`=1. A cycle with `bus_vld`=0 never produces an error, whatever its parity.
- R6: `err_pulse` is 1 for exactly the one cycle that follows each erroneous checked beat, and 0 otherwise.
- R7: `alarm` becomes 1 in the cycle after an erroneous beat. It stays 1 until a clear takes effect.
- R8: When `clr_wr`=1 in a cycle with no erroneous beat, `alarm` is 0 from the next cycle.
- R9: When `clr_wr`=1 in the same cycle as an erroneous beat, `alarm` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Beat qualifier; the beat is checked when high |
| bus_data | input | 8 | Drop bus data byte |
| bus_spe | input | 1 | Payload-envelope flag |
| bus_fj1 | input | 1 | Combined frame/J1 marker |
| bus_c1 | input | 1 | Frame-start marker |
| bus_par | input | 1 | Parity bit presented with the beat |
| trk_en | input | 1 | Pointer-tracking mode select |
| dat_only | input | 1 | Data-only coverage override (register bit) |
| clr_wr | input | 1 | Write-one-to-clear strobe for the alarm |
| err_pulse | output | 1 | One-cycle pulse per erroneous beat |
| alarm | output | 1 | Sticky parity alarm |

## Verification
The embedded properties check the alarm's timing on every cycle:
- a pulse always comes with a set alarm;
- the alarm holds unless a clear arrives;
- a clear with no error drops the alarm;
- an error together with a clear still leaves the alarm set;
- an idle cycle never yields a pulse.

Whether the right signals are included in the parity for each mode can only be shown by the bench's reference model. The model computes the expected parity from the mode inputs. The bench then flips the ignored signals and checks that the outputs are unaffected.

// File: rtl/drop_par_pkg.sv
package drop_par_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        COV_FULL = 2'd0,
        COV_PTR  = 2'd1,
        COV_DATA = 2'd2
    } cov_e;

    typedef struct packed {
        logic alarm;
        logic pulse;
    } alm_st_t;
endpackage

// File: rtl/par_cov.sv
module par_cov
    import drop_par_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              spe_i,
    input  logic              fj1_i,
    input  logic              c1_i,
    input  logic              par_i,
    input  logic              trk_en_i,
    input  logic              dat_only_i,
    output logic              bad_o
);
    cov_e cov_sel;
    logic ext_bit;

    // Coverage selection: the override takes priority over the tracking mode.
    always_comb begin
        if (dat_only_i)
            cov_sel = COV_DATA;
        else if (trk_en_i)
            cov_sel = COV_PTR;
        else
            cov_sel = COV_FULL;

        case (cov_sel)
            COV_FULL: ext_bit = spe_i ^ fj1_i;
            COV_PTR:  ext_bit = c1_i;
            default:  ext_bit = 1'b0;
        endcase

        // Odd parity: the XOR over the covered bits and the parity bit must be 1.
        bad_o = ~((^data_i) ^ ext_bit ^ par_i);
    end
endmodule

// File: rtl/par_alarm.sv
module par_alarm
    import drop_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_i,
    input  logic bad_i,
    input  logic clr_i,
    output logic alarm_o,
    output logic pulse_o
);
    alm_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit         = chk_i & bad_i;
        st_d        = st_q;
        st_d.pulse  = hit;
        if (hit)
            st_d.alarm = 1'b1;       // a set beats a clear in the same cycle
        else if (clr_i)
            st_d.alarm = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign alarm_o = st_q.alarm;
    assign pulse_o = st_q.pulse;

    // R6/R7: a pulse is always accompanied by the sticky alarm
    p_pulse_has_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> alarm_o);

    // R7: the alarm holds while there is no clear
    p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && !clr_i) |=> alarm_o);

    // R8: a clear with no error drops the alarm
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(chk_i && bad_i)) |=> !alarm_o);

    // R9: an error in the same cycle as a clear keeps the alarm set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && chk_i && bad_i) |=> (alarm_o && pulse_o));
endmodule

// File: rtl/drop_par_chk.sv
module drop_par_chk
    import drop_par_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_spe,
    input  logic              bus_fj1,
    input  logic              bus_c1,
    input  logic              bus_par,
    input  logic              trk_en,
    input  logic              dat_only,
    input  logic              clr_wr,
    output logic              err_pulse,
    output logic              alarm
);
    logic beat_bad;

    par_cov #(.DATA_W(DATA_W)) u_cov (
        .data_i     (bus_data),
        .spe_i      (bus_spe),
        .fj1_i      (bus_fj1),
        .c1_i       (bus_c1),
        .par_i      (bus_par),
        .trk_en_i   (trk_en),
        .dat_only_i (dat_only),
        .bad_o      (beat_bad)
    );

    par_alarm u_alm (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_i   (bus_vld),
        .bad_i   (beat_bad),
        .clr_i   (clr_wr),
        .alarm_o (alarm),
        .pulse_o (err_pulse)
    );

    // R5: an unqualified cycle never produces an error pulse
    p_idle_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_vld |=> !err_pulse);

    // R1: outputs are low in the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!err_pulse && !alarm));
endmodule

// File: tb/sim_drop_par_chk.sv
module sim_drop_par_chk;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_vld, bus_spe, bus_fj1, bus_c1, bus_par;
    logic [7:0] bus_data;
    logic       trk_en, dat_only, clr_wr;
    logic       err_pulse, alarm;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  m_alarm = 0;
    bit  m_pulse = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    drop_par_chk u0 (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_data(bus_data),
        .bus_spe(bus_spe), .bus_fj1(bus_fj1), .bus_c1(bus_c1), .bus_par(bus_par),
        .trk_en(trk_en), .dat_only(dat_only), .clr_wr(clr_wr),
        .err_pulse(err_pulse), .alarm(alarm)
    );

    // Reference: count ones across whatever the current mode covers.
    function automatic bit ref_bad(logic [7:0] d, bit spe, bit fj1, bit c1,
                                   bit par, bit trk, bit donly);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        if (!donly) begin
            if (trk) ones += int'(c1);
            else     ones += int'(spe) + int'(fj1);
        end
        ones += int'(par);
        return (ones % 2) == 0;
    endfunction

    // Parity bit that makes the beat correct under the given mode.
    function automatic bit good_par(logic [7:0] d, bit spe, bit fj1, bit c1,
                                    bit trk, bit donly);
        return ref_bad(d, spe, fj1, c1, 1'b0, trk, donly);
    endfunction

    task automatic check(string tag);
        n_chk++;
        if (err_pulse !== m_pulse) begin
            n_fail++;
            $display("FAIL %s err_pulse actual=%b expected=%b t=%0t", tag, err_pulse, m_pulse, $time);
        end
        n_chk++;
        if (alarm !== m_alarm) begin
            n_fail++;
            $display("FAIL %s alarm actual=%b expected=%b t=%0t", tag, alarm, m_alarm, $time);
        end
    endtask

    // Drive one cycle at negedge, step the model at posedge, compare at next negedge.
    task automatic cyc(bit vld, logic [7:0] d, bit spe, bit fj1, bit c1, bit par,
                       bit trk, bit donly, bit clr, string tag);
        bit hit;
        bus_vld = vld; bus_data = d; bus_spe = spe; bus_fj1 = fj1; bus_c1 = c1;
        bus_par = par; trk_en = trk; dat_only = donly; clr_wr = clr;
        @(posedge clk);
        hit = vld && ref_bad(d, spe, fj1, c1, par, trk, donly);
        m_pulse = hit;
        if (hit) m_alarm = 1;
        else if (clr) m_alarm = 0;
        @(negedge clk);
        check(tag);
    endtask

    task automatic clear_alarm();
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 1, "R8");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit s, f, c, p;
        rst_n = 0; bus_vld = 0; bus_data = 0; bus_spe = 0; bus_fj1 = 0;
        bus_c1 = 0; bus_par = 0; trk_en = 0; dat_only = 0; clr_wr = 0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1;
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R1");

        // R2: full coverage, good then bad beats; c1 ignored
        for (int i = 0; i < 200; i++) begin
            d = 8'($urandom); s = 1'($urandom); f = 1'($urandom); c = 1'($urandom);
            p = good_par(d, s, f, 0, 0, 0);
            if (i % 7 == 3) p = ~p;
            cyc(1, d, s, f, c, p, 0, 0, 0, "R2");
            if (i % 13 == 5) clear_alarm();
        end
        clear_alarm();
        cyc(1, 8'h01, 1, 0, 0, 1, 0, 0, 0, "R2");   // 3 ones: ok, no alarm
        cyc(1, 8'h01, 1, 1, 0, 0, 0, 0, 0, "R2");   // 3 ones: ok
        cyc(1, 8'h01, 1, 0, 0, 0, 0, 0, 0, "R2");   // 2 ones: error
        clear_alarm();

        // R3: tracking mode; spe/fj1 toggled should not matter
        for (int i = 0; i < 200; i++) begin
            d = 8'($urandom); s = 1'($urandom); f = 1'($urandom); c = 1'($urandom);
            p = good_par(d, 0, 0, c, 1, 0);
            if (i % 9 == 4) p = ~p;
            cyc(1, d, s, f, c, p, 1, 0, 0, "R3");
            if (i % 11 == 6) clear_alarm();
        end
        clear_alarm();
        cyc(1, 8'h00, 1, 0, 0, 1, 1, 0, 0, "R3");   // spe ignored: ok
        cyc(1, 8'h00, 0, 0, 1, 1, 1, 0, 0, "R3");   // c1 counted: error
        clear_alarm();

        // R4: data only in both tracking modes
        for (int i = 0; i < 200; i++) begin
            d = 8'($urandom); s = 1'($urandom); f = 1'($urandom); c = 1'($urandom);
            p = good_par(d, 0, 0, 0, 0, 1);
            if (i % 8 == 2) p = ~p;
            cyc(1, d, s, f, c, p, 1'(i % 2), 1, 0, "R4");
            if (i % 10 == 7) clear_alarm();
        end
        clear_alarm();
        cyc(1, 8'h03, 1, 1, 1, 1, 0, 1, 0, "R4");   // data 2 ones + par = 3: ok
        cyc(1, 8'h03, 1, 0, 1, 1, 1, 1, 0, "R4");   // ok in tracking mode too
        cyc(1, 8'h03, 0, 0, 0, 0, 1, 1, 0, "R4");   // even: error

        clear_alarm();
        // R5: bad parity with no qualifier
        for (int i = 0; i < 20; i++)
            cyc(0, 8'(i), 0, 0, 0, ~good_par(8'(i), 0, 0, 0, 0, 0), 0, 0, 0, "R5");

        // R6/R7: back-to-back errors, then alarm holds with good beats
        cyc(1, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R6");
        cyc(1, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 10; i++)
            cyc(1, 8'h00, 0, 0, 0, 1, 0, 0, 0, "R7");
        // R8: clear
        cyc(1, 8'h00, 0, 0, 0, 1, 0, 0, 1, "R8");
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R9: set wins over clear
        cyc(1, 8'hFF, 0, 0, 0, 0, 0, 0, 1, "R9");
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R9");
        // R1: reset mid-run clears alarm
        rst_n = 0;
        @(posedge clk); m_alarm = 0; m_pulse = 0;
        @(negedge clk);
        check("R1");
        rst_n = 1;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule